// File: doc/BRIEF.md
# Serial error status reporter

This block holds three sticky bus error flags and reports them to the local application over one status wire. The flags are: data parity error detected, target abort received and master abort received. They mirror three bits of the device status word, at bit positions 24, 28 and 29 of configuration offset 0x04. Bus events that set a flag and software clears of a flag each arrive as single-cycle pulse inputs, one per flag.

A shift-enable input picks what the wire shows. While it is high, the wire carries the OR of the three flags, so any error shows up as a single summary level. When the application sees that level and pulls shift-enable low, the block captures a snapshot of the flags. The wire then gives the individual bits one per clock in a fixed order: parity, then target abort, then master abort. After those three bits the wire reads 0 until shift-enable returns high. Raising shift-enable at any point ends the readout at once.

Top module: `err_status_rpt`

## Requirements
- R1: After reset all three flags read 0. With shift_en_i high the status wire reads 0, and the readout sequencer is idle.
- R2: A pulse on set_i[k] makes flags_o[k] 1 after the next clock edge. Index 0 is data parity error, 1 is target abort received and 2 is master abort received.
- R3: A flag stays set until a pulse on clr_i[k] clears it at the next edge. If set_i[k] and clr_i[k] are both high in the same cycle, the set wins.
- R4: While shift_en_i is high, stat_o equals the OR of flags_o in the same cycle, with no clock delay.
- R5: At the first clock edge where shift_en_i is sampled low after being high, the flags are captured. During the three cycles after that edge, stat_o gives captured bit 0, then bit 1, then bit 2.
- R6: A flag set or cleared during a readout does not change the serial bits already captured. flags_o still updates as usual.
- R7: While shift_en_i is low, stat_o reads 0 outside the three readout cycles. This covers the part of the cycle before the capture edge and every cycle after bit 2.
- R8: Raising shift_en_i during a readout returns stat_o to the OR summary in the same cycle. The next low period starts a fresh readout from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| shift_en_i | input | 1 | High: summary OR on stat_o. Low: serial readout |
| set_i | input | 3 | Per-flag error event pulses (0 parity, 1 target abort, 2 master abort) |
| clr_i | input | 3 | Per-flag write-one-to-clear pulses |
| flags_o | output | 3 | Current sticky flags, same bit order |
| stat_o | output | 1 | Shared status wire |

## Verification
Each result is due at a fixed point. Flag changes appear one edge after their set or clear pulse. The summary level follows shift_en_i within the same cycle. The three serial bits fall in the first, second and third cycles after the capture edge. The bench drives inputs on the falling edge and compares both outputs one nanosecond later against a behavioural model. The model advances only on the rising edge, using the inputs it held, so every compare falls in the cycle the requirements name. A readout aborted by shift-enable is compared in the same cycle as the rise, and so is the half-cycle of zero before a capture edge.

// File: rtl/err_rpt_pkg.sv
package err_rpt_pkg;
  localparam int unsigned ERR_N = 3;
  typedef enum int unsigned {
    ERR_PARITY    = 0,
    ERR_TGT_ABORT = 1,
    ERR_MST_ABORT = 2
  } err_idx_e;
endpackage

// File: rtl/err_flag_bank.sv
module err_flag_bank #(
  parameter int unsigned N = err_rpt_pkg::ERR_N
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else begin
      for (int i = 0; i < int'(N); i++) begin
        if (set_i[i])      flag_q[i] <= 1'b1;  // set beats clear
        else if (clr_i[i]) flag_q[i] <= 1'b0;
      end
    end
  end

  assign flags_o = flag_q;

  for (genvar g = 0; g < int'(N); g++) begin : g_chk
    // R2
    flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flag_q[g]);
    // R3
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[g] && !clr_i[g]) |=> flag_q[g]);
    // R3
    flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !set_i[g]) |=> !flag_q[g]);
  end
endmodule

// File: rtl/err_shift_seq.sv
module err_shift_seq #(
  parameter int unsigned N = err_rpt_pkg::ERR_N
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_en_i,
  input  logic [N-1:0] flags_i,
  output logic         bit_o
);
  localparam int unsigned CW = $clog2(N + 2);
  localparam logic [CW-1:0] FIRST = CW'(1);
  localparam logic [CW-1:0] LAST  = CW'(N);
  localparam logic [CW-1:0] DONE  = CW'(N + 1);

  logic          sel_q;
  logic [CW-1:0] cnt_q;
  logic [N-1:0]  shadow_q;
  logic          start;
  logic [CW-1:0] idx;

  assign start = sel_q && !shift_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= 1'b1;
      cnt_q    <= '0;
      shadow_q <= '0;
    end else begin
      sel_q <= shift_en_i;
      if (shift_en_i) cnt_q <= '0;
      else if (start) begin
        cnt_q    <= FIRST;
        shadow_q <= flags_i;
      end else if (cnt_q != '0 && cnt_q != DONE) cnt_q <= cnt_q + FIRST;
    end
  end

  assign idx   = cnt_q - FIRST;
  assign bit_o = (cnt_q >= FIRST && cnt_q <= LAST) ? shadow_q[idx] : 1'b0;

  // R5
  seq_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= DONE);
  // R5
  seq_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q && !shift_en_i) |=> (cnt_q == FIRST));
  // R6
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_en_i && cnt_q != '0) |=> $stable(shadow_q));
  // R7
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == DONE && !shift_en_i) |=> (cnt_q == DONE && !bit_o));
endmodule

// File: rtl/err_status_rpt.sv
module err_status_rpt #(
  parameter int unsigned N = err_rpt_pkg::ERR_N
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_en_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o,
  output logic         stat_o
);
  logic [N-1:0] flags;
  logic         ser_bit;

  err_flag_bank #(.N(N)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_i),
    .clr_i   (clr_i),
    .flags_o (flags)
  );

  err_shift_seq #(.N(N)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (shift_en_i),
    .flags_i    (flags),
    .bit_o      (ser_bit)
  );

  assign flags_o = flags;
  assign stat_o  = shift_en_i ? |flags : ser_bit;

  // R7
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_en_i && $past(!shift_en_i) && $past(!shift_en_i, 4)
     && $past(!shift_en_i, 2) && $past(!shift_en_i, 3)) |-> !ser_bit);
endmodule

// File: tb/err_status_rpt_test.sv
`timescale 1ns/1ps
module err_status_rpt_test;
  localparam int N = 3;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         shift_en = 1'b1;
  logic [N-1:0] set_v = '0;
  logic [N-1:0] clr_v = '0;
  logic [N-1:0] flags_o;
  logic         stat_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // model state
  int m_flags[N];
  int m_shadow[N];
  int m_phase = 0;
  int m_prev  = 1;
  int m_abort = 0;

  always #2 clk = ~clk;

  err_status_rpt #(.N(N)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .shift_en_i (shift_en),
    .set_i      (set_v),
    .clr_i      (clr_v),
    .flags_o    (flags_o),
    .stat_o     (stat_o)
  );

  task automatic compare(input string tag);
    int exp_or, exp_stat, exp_fl, differs;
    string rq;
    exp_or = 0; exp_fl = 0; differs = 0;
    for (int k = 0; k < N; k++) begin
      exp_or |= m_flags[k];
      exp_fl |= m_flags[k] << k;
      if (m_shadow[k] != m_flags[k]) differs = 1;
    end
    if (shift_en) begin
      exp_stat = exp_or;
      rq = m_abort ? "R8" : "R4";
    end else if (m_phase >= 1 && m_phase <= N) begin
      exp_stat = m_shadow[m_phase-1];
      rq = differs ? "R6" : "R5";
    end else begin
      exp_stat = 0;
      rq = "R7";
    end
    checks++;
    if (int'(stat_o) != exp_stat) begin
      fails++;
      $display("FAIL %s stat_o (%s): got %0d expected %0d", rq, tag, stat_o, exp_stat);
    end
    checks++;
    if (int'(flags_o) != exp_fl) begin
      fails++;
      $display("FAIL R2 R3 flags_o (%s): got %0d expected %0d", tag, flags_o, exp_fl);
    end
  endtask

  task automatic step(input logic sh, input logic [N-1:0] s, input logic [N-1:0] c,
                      input string tag);
    shift_en = sh; set_v = s; clr_v = c;
    #1 compare(tag);
    @(posedge clk);
    if (sh) begin
      if (m_phase >= 1 && m_phase <= N) m_abort = 1;
      m_phase = 0;
    end else begin
      m_abort = 0;
      if (m_prev) begin
        for (int k = 0; k < N; k++) m_shadow[k] = m_flags[k];
        m_phase = 1;
      end else if (m_phase >= 1 && m_phase <= N) m_phase++;
    end
    m_prev = sh;
    for (int k = 0; k < N; k++) begin
      if (s[k]) m_flags[k] = 1;
      else if (c[k]) m_flags[k] = 0;
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N; k++) begin m_flags[k] = 0; m_shadow[k] = 0; end
    repeat (2) @(negedge clk);
    #1 compare("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    step(1, 3'b000, 3'b000, "R1 after reset");
    step(1, 3'b001, 3'b000, "R2 set parity");
    step(1, 3'b000, 3'b000, "R4 summary high");
    repeat (3) step(1, 3'b000, 3'b000, "R3 sticky");
    // readout with parity only (R5), then idle zero (R7)
    repeat (7) step(0, 3'b000, 3'b000, "R5 readout 100");
    step(1, 3'b100, 3'b000, "R2 set master abort");
    step(1, 3'b000, 3'b001, "R3 clear parity");
    step(1, 3'b000, 3'b000, "R4 master only");
    repeat (5) step(0, 3'b000, 3'b000, "R5 readout 001");
    // R6: events during readout do not disturb snapshot
    step(1, 3'b010, 3'b000, "R2 set target abort");
    step(0, 3'b001, 3'b000, "R6 capture edge");
    step(0, 3'b000, 3'b100, "R6 parity bit");
    step(0, 3'b000, 3'b010, "R6 target bit");
    step(0, 3'b000, 3'b000, "R6 master bit");
    step(0, 3'b000, 3'b000, "R7 done");
    // R3 set beats clear
    step(1, 3'b110, 3'b110, "R3 set vs clear");
    step(1, 3'b000, 3'b000, "R3 after race");
    // R8 abort mid sequence then restart
    step(0, 3'b000, 3'b000, "R8 capture");
    step(0, 3'b000, 3'b000, "R8 bit0");
    step(1, 3'b000, 3'b000, "R8 abort");
    step(1, 3'b000, 3'b000, "R4 after abort");
    repeat (6) step(0, 3'b000, 3'b000, "R8 restart");
    // clear everything, summary falls
    step(1, 3'b000, 3'b111, "R3 clear all");
    step(1, 3'b000, 3'b000, "R4 none");
    repeat (5) step(0, 3'b000, 3'b000, "R7 empty readout");
    step(1, 3'b111, 3'b000, "R2 set all");
    repeat (5) step(0, 3'b000, 3'b000, "R5 readout 111");
    step(1, 3'b000, 3'b000, "R4 final");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule